// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Status Flags

This block is a single-clock first-in first-out buffer for 18-bit words, with a depth that is a power of two and set by a parameter. Producers push a word by pulling the active-low write enable low. Consumers pop a word by pulling the active-low read enable low. The buffer refuses to overflow or underflow: a push while full and a pop while empty are ignored. The read data register keeps the last word that was actually popped.

Five active-low status flags report the fill level: empty, almost empty, half full, almost full and full. The almost-empty threshold is counted up from zero words, and the almost-full threshold is counted down from the full depth. Both come in as offset inputs. Each flag is registered, so it describes the occupancy that results from the operations of the current edge.

An active-high rewind input sets the read position back to physical slot zero. The data stored so far can then be replayed. This is useful for resending a packet that was not acknowledged.

Top module: `sync_flag_fifo`

## Requirements
- R1: With write enable low and full_n high on a rising edge (rewind low), `wdata` is stored and occupancy rises by one, unless a read is also accepted on that edge.
- R2: While full_n is low, a write request is ignored. No word is stored, and the words already held are read out unchanged and in order.
- R3: With read enable low and empty_n high on a rising edge (rewind low), the oldest word is placed in `rdata`. While empty_n is low, read requests are ignored and `rdata` holds the last word read.
- R4: While rst_n is low, the buffer is empty and `rdata` is 0. The flags then read empty_n=0, almost_empty_n=0, half_full_n=1, almost_full_n=1 and full_n=1, and no request is accepted.
- R5: empty_n is low exactly at 0 words. almost_empty_n is low when the word count is at most `ae_offset`.
- R6: half_full_n is low when the word count is at least DEPTH/2+1.
- R7: almost_full_n is low when the word count is at least DEPTH−`af_offset`. full_n is low exactly at DEPTH words.
- R8: When a read and a write are both accepted on one edge, the occupancy and every flag stay the same.
- R9: A high level on `rewind` during an edge sets the read position to slot zero, keeps the write position, and sets the occupancy to the number of words written since reset. Later reads replay the stored words from the first one.
- R10: On an edge where `rewind` is high, the write and read enables have no effect.
- R11: A word written into an empty buffer raises empty_n on the same edge. A read on the next edge delivers that word to `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write request, active low |
| rd_en_n | input | 1 | Read request, active low |
| rewind | input | 1 | Rewind the read position to slot zero, active high |
| wdata | input | DATA_W | Word to store |
| ae_offset | input | ADDR_W | Almost-empty threshold, in words from empty |
| af_offset | input | ADDR_W | Almost-full threshold, in words from full |
| rdata | output | DATA_W | Last word read |
| empty_n | output | 1 | Low when the buffer holds no words |
| almost_empty_n | output | 1 | Low when the word count is at most ae_offset |
| half_full_n | output | 1 | Low when the word count exceeds half the depth |
| almost_full_n | output | 1 | Low when the word count is at least DEPTH−af_offset |
| full_n | output | 1 | Low when the buffer holds DEPTH words |

## Verification
The properties take the two offsets as quasi-static: they change only while reset is held. They also assume that rewind is used only after no more than DEPTH accepted writes since the last reset, because the replay count is undefined beyond that point. The stimulus follows both rules. The bench picks the offsets before releasing reset, counts the writes it has had accepted, and raises rewind at random only while that count is within the depth. Requests against a full or empty buffer are sent freely, since the block must tolerate them.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
   typedef struct packed {
      logic empty_n;
      logic aempty_n;
      logic hfull_n;
      logic afull_n;
      logic full_n;
   } flag_vec_t;

   localparam flag_vec_t FLAGS_AT_RESET = '{empty_n: 1'b0, aempty_n: 1'b0,
                                            hfull_n: 1'b1, afull_n: 1'b1,
                                            full_n: 1'b1};
endpackage

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              rd_ok,
   input  logic              rewind,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   cnt_nx
);
   localparam int CW = ADDR_W + 1;

   logic [CW-1:0] wpos;
   logic [CW-1:0] rpos;
   logic [CW-1:0] cnt;

   assign waddr = wpos[ADDR_W-1:0];
   assign raddr = rpos[ADDR_W-1:0];

   always_comb begin
      if (rewind)
         cnt_nx = wpos;
      else if (wr_ok && !rd_ok)
         cnt_nx = cnt + CW'(1);
      else if (rd_ok && !wr_ok)
         cnt_nx = cnt - CW'(1);
      else
         cnt_nx = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpos <= '0;
         rpos <= '0;
         cnt  <= '0;
      end else begin
         cnt <= cnt_nx;
         if (wr_ok)
            wpos <= wpos + CW'(1);
         if (rewind)
            rpos <= '0;
         else if (rd_ok)
            rpos <= rpos + CW'(1);
      end
   end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (re)
         rdata <= mem[raddr];
   end
endmodule

// File: rtl/fifo_flag_decode.sv
module fifo_flag_decode
   import fifo_flag_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W:0]   cnt_nx,
   input  logic [ADDR_W-1:0] ae_offset,
   input  logic [ADDR_W-1:0] af_offset,
   output flag_vec_t         flags
);
   localparam int CW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_UP  = CW'(DEPTH / 2 + 1);

   flag_vec_t nx;

   always_comb begin
      nx.empty_n  = (cnt_nx != '0);
      nx.aempty_n = !(cnt_nx <= {1'b0, ae_offset});
      nx.hfull_n  = !(cnt_nx >= HALF_UP);
      nx.afull_n  = !(cnt_nx >= (FULL_CNT - {1'b0, af_offset}));
      nx.full_n   = (cnt_nx != FULL_CNT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= FLAGS_AT_RESET;
      else
         flags <= nx;
   end
endmodule

// File: rtl/sync_flag_fifo.sv
module sync_flag_fifo
   import fifo_flag_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              rewind,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ae_offset,
   input  logic [ADDR_W-1:0] af_offset,
   output logic [DATA_W-1:0] rdata,
   output logic              empty_n,
   output logic              almost_empty_n,
   output logic              half_full_n,
   output logic              almost_full_n,
   output logic              full_n
);
   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_depth
         $error("sync_flag_fifo: ADDR_W must lie in 2..12");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sync_flag_fifo: DATA_W must be positive");
      end
   endgenerate

   flag_vec_t         flags;
   logic              wr_ok;
   logic              rd_ok;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic [ADDR_W:0]   cnt_nx;

   assign wr_ok = !wr_en_n && flags.full_n  && !rewind;
   assign rd_ok = !rd_en_n && flags.empty_n && !rewind;

   fifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok),
      .rewind (rewind),
      .waddr  (waddr),
      .raddr  (raddr),
      .cnt_nx (cnt_nx)
   );

   fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (waddr),
      .wdata (wdata),
      .re    (rd_ok),
      .raddr (raddr),
      .rdata (rdata)
   );

   fifo_flag_decode #(.ADDR_W(ADDR_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_nx    (cnt_nx),
      .ae_offset (ae_offset),
      .af_offset (af_offset),
      .flags     (flags)
   );

   assign empty_n        = flags.empty_n;
   assign almost_empty_n = flags.aempty_n;
   assign half_full_n    = flags.hfull_n;
   assign almost_full_n  = flags.afull_n;
   assign full_n         = flags.full_n;
endmodule

// File: rtl/fifo_flag_checker.sv
module fifo_flag_checker #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en_n,
   input logic              rewind,
   input logic [DATA_W-1:0] rdata,
   input logic              empty_n,
   input logic              almost_empty_n,
   input logic              half_full_n,
   input logic              almost_full_n,
   input logic              full_n
);
   // R4: one edge after reset is seen low, the buffer is empty and the output is cleared
   a_r4_reset_empty: assert property (@(posedge clk)
      !rst_n |=> (!empty_n && rdata == '0));

   // R3: nothing can be read while empty, so the output word holds
   a_r3_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> $stable(rdata));

   // R2: a full buffer with no read and no rewind stays full
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && rd_en_n && !rewind) |=> !full_n);

   // R5: zero words lies inside the almost-empty band
   a_r5_empty_in_band: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !almost_empty_n);

   // R7: a full buffer is also almost full and past half
   a_r7_full_in_band: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> (!almost_full_n && !half_full_n));

   // R6: past half full means the buffer is not empty
   a_r6_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !half_full_n |-> empty_n);
endmodule

bind sync_flag_fifo fifo_flag_checker #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_en_n        (rd_en_n),
   .rewind         (rewind),
   .rdata          (rdata),
   .empty_n        (empty_n),
   .almost_empty_n (almost_empty_n),
   .half_full_n    (half_full_n),
   .almost_full_n  (almost_full_n),
   .full_n         (full_n)
);

// File: tb/tb_sync_flag_fifo.sv
module tb_sync_flag_fifo;
   localparam int DATA_W = 18;
   localparam int ADDR_W = 6;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en_n = 1'b1;
   logic              rd_en_n = 1'b1;
   logic              rewind = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [ADDR_W-1:0] ae_offset = 6'd5;
   logic [ADDR_W-1:0] af_offset = 6'd7;
   logic [DATA_W-1:0] rdata;
   logic empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench reference state
   logic [DATA_W-1:0] m_mem [DEPTH];
   int m_wp, m_rp, m_cnt, m_tot;
   logic [DATA_W-1:0] m_rdata;

   always #10 clk = ~clk;

   sync_flag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
      .rewind(rewind), .wdata(wdata), .ae_offset(ae_offset),
      .af_offset(af_offset), .rdata(rdata), .empty_n(empty_n),
      .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
      .almost_full_n(almost_full_n), .full_n(full_n)
   );

   function automatic logic x_empty(int c);   return c != 0; endfunction
   function automatic logic x_aempty(int c);  return !(c <= int'(ae_offset)); endfunction
   function automatic logic x_hfull(int c);   return !(c >= DEPTH / 2 + 1); endfunction
   function automatic logic x_afull(int c);   return !(c >= DEPTH - int'(af_offset)); endfunction
   function automatic logic x_full(int c);    return c != DEPTH; endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R3 rdata", int'(rdata), int'(m_rdata));
      check("R5 empty_n", int'(empty_n), int'(x_empty(m_cnt)));
      check("R5 almost_empty_n", int'(almost_empty_n), int'(x_aempty(m_cnt)));
      check("R6 half_full_n", int'(half_full_n), int'(x_hfull(m_cnt)));
      check("R7 almost_full_n", int'(almost_full_n), int'(x_afull(m_cnt)));
      check("R7 full_n", int'(full_n), int'(x_full(m_cnt)));
   endtask

   // one clock: drive at a falling edge, update the reference, compare at the next falling edge
   task automatic cyc(bit wn, bit rn, bit rt, logic [DATA_W-1:0] d);
      bit w_ok, r_ok;
      wr_en_n = wn; rd_en_n = rn; rewind = rt; wdata = d;
      w_ok = !wn && m_cnt != DEPTH && !rt;
      r_ok = !rn && m_cnt != 0 && !rt;
      if (rt) begin
         m_rp = 0;
         m_cnt = m_wp;
      end else begin
         if (r_ok) begin
            m_rdata = m_mem[m_rp % DEPTH];
            m_rp++;
         end
         if (w_ok) begin
            m_mem[m_wp % DEPTH] = d;
            m_wp++;
            m_tot++;
         end
         m_cnt = m_cnt + int'(w_ok) - int'(r_ok);
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset(logic [ADDR_W-1:0] ae, logic [ADDR_W-1:0] af);
      rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; rewind = 1'b0;
      ae_offset = ae; af_offset = af;
      m_wp = 0; m_rp = 0; m_cnt = 0; m_tot = 0; m_rdata = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic rand_phase(int n, int wprob, int rprob);
      for (int i = 0; i < n; i++) begin
         bit rt;
         rt = (m_tot <= DEPTH) && (($urandom % 60) == 0);
         cyc(($urandom % 100) >= wprob, ($urandom % 100) >= rprob, rt,
             DATA_W'($urandom));
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24680));
      do_reset(6'd5, 6'd7);
      // R4: state during and right after reset
      check("R4 rdata cleared", int'(rdata), 0);
      check("R4 empty_n", int'(empty_n), 0);
      check("R4 almost_empty_n", int'(almost_empty_n), 0);
      check("R4 half_full_n", int'(half_full_n), 1);
      check("R4 full_n", int'(full_n), 1);

      // R11 and R1: first word latency
      cyc(1'b0, 1'b1, 1'b0, 18'h1A5A5);
      check("R11 empty_n up after first write", int'(empty_n), 1);
      cyc(1'b1, 1'b0, 1'b0, '0);
      check("R11 first word on output", int'(rdata), 32'h1A5A5);

      // R3: read on empty is ignored, output holds
      cyc(1'b1, 1'b0, 1'b0, '0);
      check("R3 hold on empty read", int'(rdata), 32'h1A5A5);

      // R1, R2, R7: fill completely, then try an extra write
      for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b1, 1'b0, DATA_W'(32'h100 + i));
      check("R7 full_n at depth", int'(full_n), 0);
      cyc(1'b0, 1'b1, 1'b0, 18'h3FFFF);
      check("R2 still full after extra write", int'(full_n), 0);
      for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b0, '0);
      check("R2 last word unchanged", int'(rdata), 32'h100 + DEPTH - 1);
      check("R2 empty after draining depth", int'(empty_n), 0);

      // R8: simultaneous read and write keep the count
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, DATA_W'(32'h200 + i));
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0, DATA_W'(32'h300 + i));
      check("R8 still almost empty at 3 words", int'(almost_empty_n), 0);
      check("R8 not empty", int'(empty_n), 1);

      // R9 and R10: rewind with both enables active
      do_reset(6'd5, 6'd7);
      for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, DATA_W'(32'h400 + i));
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, '0);
      cyc(1'b0, 1'b0, 1'b1, 18'h2BEEF);
      check("R9 almost_empty_n high after rewind to 10 words", int'(almost_empty_n), 1);
      check("R10 rdata untouched by read during rewind", int'(rdata), 32'h403);
      cyc(1'b1, 1'b0, 1'b0, '0);
      check("R9 replay starts at first word", int'(rdata), 32'h400);
      for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 1'b0, '0);
      check("R10 write during rewind not stored", int'(empty_n), 0);
      check("R9 replay ends at last word", int'(rdata), 32'h409);

      // random phases with two offset settings
      do_reset(6'd5, 6'd7);
      rand_phase(2500, 75, 35);
      rand_phase(2500, 35, 75);
      rand_phase(2500, 55, 55);
      do_reset(6'd0, 6'd31);
      rand_phase(2500, 70, 40);
      rand_phase(2500, 45, 60);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule